// File: doc/BRIEF.md
# Serial Link Error Status Register

This block holds the sticky error status word of one serial storage link port. The link and PHY layers report faults as single-cycle pulses. Each pulse sets its own fixed bit of a 32-bit status word, and that bit stays set until software clears it. The block also watches the PHY-ready level. Every change of that level, rising or falling, sets a dedicated status bit. A port-change interrupt is raised from that bit when software has enabled it.

Software works through a simple register port with a single-cycle write strobe and a combinational read.

- Address 0 is the status word. Writing a 1 to a bit clears that bit; writing a 0 leaves it alone.
- Address 1 is a small control word. It shows the port-change interrupt status and holds the interrupt enable.

The map keeps recovered, unrecovered-transient and persistent error classes apart, so software can grade how serious a fault is from its bit position alone.

Top module: `link_err_status`

## Requirements
- R1: A one-cycle pulse on an event input sets its status bit, readable at address 0 from the clock edge that samples the pulse onward. Each event input sets this bit:

  | Event input | Status bit |
  |---|---|
  | `recDataEvt` | 0 |
  | `recCommEvt` | 1 |
  | `transientEvt` | 8 |
  | `persistEvt` | 9 |
  | `protoEvt` | 10 |
  | `memAbortEvt` | 11 |
  | `phyIntEvt` | 17 |
  | `wakeEvt` | 18 |
  | `decodeEvt` | 19 |
  | `crcEvt` | 21 |

  Several pulses in one cycle set all of their bits.
- R2: A status bit that is set stays set until it is cleared. Further pulses of the same event leave the word unchanged.
- R3: A write to address 0 clears every status bit whose write-data bit is 1. Bits whose write-data bit is 0 keep their value.
- R4: When an event pulse and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R5: Bits 2 to 7, 12 to 15 and 20 always read 0, both after any events and after any writes.
- R6: Status bit 16 sets on the clock edge at which the `phyReady` input differs from its value at the previous edge. This applies to falling and rising changes alike. A steady `phyReady` never sets bit 16.
- R7: At address 1, bit 0 reads as a copy of status bit 16, and writes to it have no effect. Bit 1 is the interrupt enable, which can be both read and written. All other bits read 0.
- R8: `irq` is a level that is high exactly while status bit 16 and the enable bit are both 1.
- R9: Synchronous reset clears the status word and the enable bit. A `phyReady` held high through reset and after it does not set bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| recDataEvt | input | 1 | Recovered data integrity error pulse |
| recCommEvt | input | 1 | Recovered communications error pulse |
| transientEvt | input | 1 | Unrecovered transient data integrity error pulse |
| persistEvt | input | 1 | Persistent communication error pulse |
| protoEvt | input | 1 | Protocol violation pulse |
| memAbortEvt | input | 1 | Memory access abort pulse |
| phyIntEvt | input | 1 | PHY internal error pulse |
| wakeEvt | input | 1 | Comm-wake detected pulse |
| decodeEvt | input | 1 | 10b-to-8b decode error pulse |
| crcEvt | input | 1 | Link CRC error pulse |
| phyReady | input | 1 | PHY-ready level |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | ADDR_W | Write address |
| wrData | input | 32 | Write data |
| rdAddr | input | ADDR_W | Read address |
| rdData | output | 32 | Read data, combinational |
| irq | output | 1 | Port-change interrupt level |

## Verification
The hardest case to reach from the ports is an event pulse that lands in the same cycle as a clearing write to its own bit. The bench produces it by driving the event and an all-ones write to address 0 on the same negative edge. It then checks that only that bit survives.

A reset taken while `phyReady` is high is the other delicate case. The bench holds the level high through reset and checks that bit 16 stays clear afterwards.

All 1024 combinations of the ten event inputs are swept. Each is checked against a word computed from the bit table, and each sweep step ends with a zero write and an all-ones write.

// File: rtl/lerr_pkg.sv
package lerr_pkg;

  localparam int STATUS_W   = 32;
  localparam int NUM_EVT    = 10;
  localparam int CHANGE_BIT = 16;

  typedef logic [STATUS_W-1:0] word_t;

  typedef struct packed {
    word_t clrMask;
    logic  enLoad;
    logic  enValue;
  } strobe_t;

  // bit position of each event source, by input index
  function automatic int evtPos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 1;
      2:       return 8;
      3:       return 9;
      4:       return 10;
      5:       return 11;
      6:       return 17;
      7:       return 18;
      8:       return 19;
      9:       return 21;
      default: return 0;
    endcase
  endfunction

  function automatic word_t implMask();
    word_t m;
    m = '0;
    for (int i = 0; i < NUM_EVT; i++) m[evtPos(i)] = 1'b1;
    m[CHANGE_BIT] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/lerr_sticky_bit.sv
module lerr_sticky_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic setPulse,
  input  logic clrPulse,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= setPulse | (q & ~clrPulse);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    setPulse |=> q); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !clrPulse) |=> q); // R2
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clrPulse && !setPulse) |=> !q); // R3

endmodule

// File: rtl/lerr_ctrl.sv
module lerr_ctrl
  import lerr_pkg::*;
#(
  parameter int ADDR_W      = 2,
  parameter int ADDR_STATUS = 0,
  parameter int ADDR_CTRL   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  word_t             wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  input  word_t             statusW,
  input  logic              enableQ,
  output strobe_t           strobe,
  output word_t             rdData
);

  localparam word_t IMPL = implMask();

  logic hitStatus;
  logic hitCtrl;

  assign hitStatus = wrEn && (wrAddr == ADDR_W'(ADDR_STATUS));
  assign hitCtrl   = wrEn && (wrAddr == ADDR_W'(ADDR_CTRL));

  always_comb begin
    strobe.clrMask = hitStatus ? (wrData & IMPL) : '0;
    strobe.enLoad  = hitCtrl;
    strobe.enValue = wrData[1];
  end

  always_comb begin
    rdData = '0;
    if (rdAddr == ADDR_W'(ADDR_STATUS)) begin
      rdData = statusW;
    end else if (rdAddr == ADDR_W'(ADDR_CTRL)) begin
      rdData[0] = statusW[CHANGE_BIT];
      rdData[1] = enableQ;
    end
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == ADDR_W'(ADDR_STATUS)) |-> ((rdData & ~IMPL) == '0)); // R5
  AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rdAddr == ADDR_W'(ADDR_CTRL)) |-> (rdData[STATUS_W-1:2] == '0)); // R7

endmodule

// File: rtl/lerr_datapath.sv
module lerr_datapath
  import lerr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evtIn,
  input  logic               phyReady,
  input  strobe_t            strobe,
  output word_t              statusW,
  output logic               enableQ,
  output logic               irq
);

  logic [NUM_EVT-1:0] evtQ;
  logic               prevPhy;
  logic               phyChange;
  logic               chgQ;
  logic               unusedClr;

  always_ff @(posedge clk) begin
    if (!rst_n) prevPhy <= phyReady;
    else        prevPhy <= phyReady;
  end

  assign phyChange = phyReady ^ prevPhy;

  for (genvar i = 0; i < NUM_EVT; i++) begin : gEvt
    localparam int POS = evtPos(i);
    lerr_sticky_bit uBit (
      .clk      (clk),
      .rst_n    (rst_n),
      .setPulse (evtIn[i]),
      .clrPulse (strobe.clrMask[POS]),
      .q        (evtQ[i])
    );
  end

  lerr_sticky_bit uChange (
    .clk      (clk),
    .rst_n    (rst_n),
    .setPulse (phyChange),
    .clrPulse (strobe.clrMask[CHANGE_BIT]),
    .q        (chgQ)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)            enableQ <= 1'b0;
    else if (strobe.enLoad) enableQ <= strobe.enValue;
  end

  always_comb begin
    statusW = '0;
    for (int i = 0; i < NUM_EVT; i++) statusW[evtPos(i)] = evtQ[i];
    statusW[CHANGE_BIT] = chgQ;
  end

  assign irq = chgQ & enableQ;

  assign unusedClr = ^(strobe.clrMask & ~implMask());

  AST_CHANGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (phyReady != prevPhy) |=> statusW[CHANGE_BIT]); // R6
  AST_EN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.enLoad |=> (enableQ == $past(strobe.enValue))); // R7
  AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.enLoad |=> $stable(enableQ)); // R7
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !enableQ |-> !irq); // R8

endmodule

// File: rtl/link_err_status.sv
module link_err_status
  import lerr_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              recDataEvt,
  input  logic              recCommEvt,
  input  logic              transientEvt,
  input  logic              persistEvt,
  input  logic              protoEvt,
  input  logic              memAbortEvt,
  input  logic              phyIntEvt,
  input  logic              wakeEvt,
  input  logic              decodeEvt,
  input  logic              crcEvt,
  input  logic              phyReady,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              irq
);

  logic [NUM_EVT-1:0] evtVec;
  strobe_t            strobe;
  word_t              statusW;
  logic               enableQ;

  assign evtVec = {crcEvt, decodeEvt, wakeEvt, phyIntEvt, memAbortEvt,
                   protoEvt, persistEvt, transientEvt, recCommEvt, recDataEvt};

  lerr_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .rdAddr  (rdAddr),
    .statusW (statusW),
    .enableQ (enableQ),
    .strobe  (strobe),
    .rdData  (rdData)
  );

  lerr_datapath uData (
    .clk      (clk),
    .rst_n    (rst_n),
    .evtIn    (evtVec),
    .phyReady (phyReady),
    .strobe   (strobe),
    .statusW  (statusW),
    .enableQ  (enableQ),
    .irq      (irq)
  );

endmodule

// File: tb/tb_link_err_status.sv
module tb_link_err_status;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  evtDrv;
  logic        phyReady;
  logic        wrEn;
  logic [1:0]  wrAddr;
  logic [31:0] wrData;
  logic [1:0]  rdAddr;
  logic [31:0] rdData;
  logic        irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int posTab[10] = '{0, 1, 8, 9, 10, 11, 17, 18, 19, 21};

  always #(CLK_PERIOD/2) clk = ~clk;

  link_err_status dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .recDataEvt   (evtDrv[0]),
    .recCommEvt   (evtDrv[1]),
    .transientEvt (evtDrv[2]),
    .persistEvt   (evtDrv[3]),
    .protoEvt     (evtDrv[4]),
    .memAbortEvt  (evtDrv[5]),
    .phyIntEvt    (evtDrv[6]),
    .wakeEvt      (evtDrv[7]),
    .decodeEvt    (evtDrv[8]),
    .crcEvt       (evtDrv[9]),
    .phyReady     (phyReady),
    .wrEn         (wrEn),
    .wrAddr       (wrAddr),
    .wrData       (wrData),
    .rdAddr       (rdAddr),
    .rdData       (rdData),
    .irq          (irq)
  );

  function automatic logic [31:0] expWord(input logic [9:0] m);
    logic [31:0] w;
    w = '0;
    for (int i = 0; i < 10; i++) if (m[i]) w[posTab[i]] = 1'b1;
    return w;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readAt(input logic [1:0] a, output logic [31:0] v);
    rdAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    cycle();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulse(input logic [9:0] m);
    evtDrv = m;
    cycle();
    evtDrv = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; evtDrv = '0; phyReady = 1'b1;
    wrEn = 1'b0; wrAddr = '0; wrData = '0; rdAddr = '0;
    @(negedge clk);
    cycle(); cycle();
    rst_n = 1'b1;
    cycle(); cycle();

    // R9: reset state, phyReady high gives no change event
    readAt(2'd0, v); check("R9 status after reset", v, 32'h0);
    readAt(2'd1, v); check("R9 ctrl after reset", v, 32'h0);
    check("R9 irq after reset", {31'b0, irq}, 32'h0);

    // R1 R3 R5: exhaustive sweep over event combinations
    for (int m = 0; m < 1024; m++) begin
      pulse(10'(m));
      readAt(2'd0, v); check("R1 event map", v, expWord(10'(m)));
      writeReg(2'd0, 32'h0);
      readAt(2'd0, v); check("R3 zero write keeps", v, expWord(10'(m)));
      writeReg(2'd0, 32'hFFFF_FFFF);
      readAt(2'd0, v); check("R3 ones write clears", v, 32'h0);
    end

    // R3: partial clear of chosen bits
    pulse(10'h3FF);
    writeReg(2'd0, 32'h0020_0101);
    readAt(2'd0, v); check("R3 partial clear", v, expWord(10'h3FF) & ~32'h0020_0101);

    // R2: repeated pulses do not change set bits
    writeReg(2'd0, 32'hFFFF_FFFF);
    pulse(10'h010);
    pulse(10'h010);
    pulse(10'h010);
    readAt(2'd0, v); check("R2 repeat pulse", v, 32'h0000_0400);
    cycle(); cycle();
    readAt(2'd0, v); check("R2 stays set", v, 32'h0000_0400);

    // R4: event and clear in same cycle
    writeReg(2'd0, 32'hFFFF_FFFF);
    pulse(10'h3FF);
    evtDrv = 10'h200;
    writeReg(2'd0, 32'hFFFF_FFFF);
    evtDrv = '0;
    readAt(2'd0, v); check("R4 set beats clear", v, 32'h0020_0000);

    // R5: writes to reserved bits from clean state
    writeReg(2'd0, 32'hFFFF_FFFF);
    writeReg(2'd0, 32'h001F_F0FC);
    readAt(2'd0, v); check("R5 reserved read zero", v, 32'h0);

    // R6: falling change
    phyReady = 1'b0;
    cycle();
    readAt(2'd0, v); check("R6 falling sets bit16", v, 32'h0001_0000);
    readAt(2'd1, v); check("R7 mirror bit0", v, 32'h1);
    writeReg(2'd0, 32'h0001_0000);
    cycle(); cycle();
    readAt(2'd0, v); check("R6 steady no set", v, 32'h0);
    phyReady = 1'b1;
    cycle();
    readAt(2'd0, v); check("R6 rising sets bit16", v, 32'h0001_0000);

    // R7: bit0 read-only, enable read/write
    writeReg(2'd1, 32'h0000_0001);
    readAt(2'd1, v); check("R7 bit0 write ignored", v, 32'h1);
    check("R8 irq disabled", {31'b0, irq}, 32'h0);
    writeReg(2'd1, 32'hFFFF_FFFE);
    readAt(2'd1, v); check("R7 enable set", v, 32'h3);
    check("R8 irq asserted", {31'b0, irq}, 32'h1);
    cycle();
    check("R8 irq level held", {31'b0, irq}, 32'h1);
    writeReg(2'd0, 32'h0001_0000);
    check("R8 irq drops on clear", {31'b0, irq}, 32'h0);
    readAt(2'd1, v); check("R7 enable kept", v, 32'h2);
    phyReady = 1'b0;
    cycle();
    check("R8 irq on new change", {31'b0, irq}, 32'h1);
    writeReg(2'd1, 32'h0);
    check("R8 irq off by enable", {31'b0, irq}, 32'h0);

    // R9: reset with state set and phyReady high
    pulse(10'h3FF);
    writeReg(2'd1, 32'h2);
    phyReady = 1'b1;
    rst_n = 1'b0;
    cycle(); cycle();
    rst_n = 1'b1;
    cycle(); cycle();
    readAt(2'd0, v); check("R9 status cleared", v, 32'h0);
    readAt(2'd1, v); check("R9 enable cleared", v, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule